// File: doc/BRIEF.md
# Programmable Down-Counter and Square-Wave Timer

This block is the counter/timer of a serial-port peripheral. It holds a 16-bit down-counter that advances on one of several clock enables chosen by a 3-bit configuration code. The same code sets whether the block is a one-shot counter or a free-running timer. Every clock source is a single-cycle enable pulse in the system clock domain. A 4-bit prescaler can divide some of the sources by 16.

In counter mode, a start strobe loads the preload value. The counter then steps down once per advance. It stops at zero and raises a sticky ready flag, which a stop strobe clears. In timer mode the counter reloads itself each time it runs out and toggles a square-wave output, so the full period is twice the preload value. The configuration code and the two preload bytes are written through a small byte-wide register port.

Top module: `ctr_timer`

## Requirements
- R1: After reset, count is 0, ready is 0, sq_out is 0, the configuration code is 000 and the preload is 0.
- R2: A write with wr_sel=0 sets the code to wr_data[2:0]. wr_sel=1 writes preload bits 7:0 and wr_sel=2 writes preload bits 15:8. wr_sel=3 is ignored. A code write also loads count from the preload value held before that edge, clears ready, sq_out and the prescaler, and halts counting. A code write takes priority over every other action in the same cycle.
- R3: The advance source for each code is: 000 ext_tick, 001 txc_tick, 011 xtal_tick/16, 100 ext_tick, 101 ext_tick/16, 110 xtal_tick, 111 xtal_tick/16. Codes 0xx are counter mode and codes 1xx are timer mode.
- R4: Code 010 is reserved. No tick on any input changes count.
- R5: For the divided codes, the counter advances on every 16th tick of the source, counted from the last code write or start.
- R6: In counter mode, start loads count from the preload and clears ready. Each advance then decrements count. The advance that reaches zero sets ready and halts counting. With a preload of 0, the first advance sets ready.
- R7: A stop strobe clears ready and halts counting without changing count. Stop wins over start in the same cycle.
- R8: In timer mode, an advance with count at most 1 reloads count from the preload and toggles sq_out. Any other advance decrements count. A half period is therefore max(preload,1) advances. In counter mode, sq_out stays 0.
- R9: In timer mode, start reloads count from the preload, clears sq_out and restarts the prescaler.
- R10: In counter mode, once counting has halted, source ticks change neither count nor ready until the next start or code write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 code, 1 preload low byte, 2 preload high byte |
| wr_data | input | 8 | Write data |
| start | input | 1 | Start / reload strobe |
| stop | input | 1 | Stop strobe, clears ready |
| ext_tick | input | 1 | External pin clock enable |
| txc_tick | input | 1 | Transmitter 1x clock enable |
| xtal_tick | input | 1 | Crystal clock enable |
| count | output | 16 | Current counter value |
| ready | output | 1 | Sticky terminal-count flag (counter mode) |
| sq_out | output | 1 | Square-wave output (timer mode) |

## Verification
Assertions are evaluated on every cycle and check the following:
- The reserved code freezes the count.
- A halted counter holds both its count and its ready flag.
- Ready rises only together with a zero count.
- Stop always leaves ready low.
- sq_out stays low in counter mode.
- In timer mode, sq_out never changes while the count is above one.

Other behaviours need the bench's scenarios to show them:
- Which tick source each code selects.
- The exact 16-tick spacing of the prescaler.
- The square-wave half period.
- Reload from the preload value.
- The ignored register select.

The random phase checks these against a cycle-by-cycle reference model.

// File: rtl/ctr_timer.sv
module ctr_timer #(
  parameter int CW  = 16,
  parameter int PSW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          start,
  input  logic          stop,
  input  logic          ext_tick,
  input  logic          txc_tick,
  input  logic          xtal_tick,
  output logic [CW-1:0] count,
  output logic          ready,
  output logic          sq_out
);
  localparam int HBW = CW - 8;

  logic [2:0]     mode_q;
  logic [CW-1:0]  pre_q, cnt_q;
  logic [PSW-1:0] ps_q;
  logic           run_q, rdy_q, sq_q;
  logic           src, div_sel, adv, mode_wr, timer_md, at_end;

  always_comb begin
    unique case (mode_q)
      3'b000, 3'b100, 3'b101: src = ext_tick;
      3'b001:                 src = txc_tick;
      3'b011, 3'b110, 3'b111: src = xtal_tick;
      default:                src = 1'b0;
    endcase
  end

  assign div_sel  = (mode_q == 3'b011) || (mode_q == 3'b101) || (mode_q == 3'b111);
  assign adv      = div_sel ? (src && (&ps_q)) : src;
  assign mode_wr  = wr_en && (wr_sel == 2'd0);
  assign timer_md = mode_q[2];
  assign at_end   = (cnt_q <= CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == 2'd1) pre_q[7:0]    <= wr_data;
      if (wr_sel == 2'd2) pre_q[CW-1:8] <= wr_data[HBW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      cnt_q  <= '0;
      ps_q   <= '0;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      sq_q   <= 1'b0;
    end else if (mode_wr) begin
      mode_q <= wr_data[2:0];
      cnt_q  <= pre_q;
      ps_q   <= '0;
      run_q  <= 1'b0;
      rdy_q  <= 1'b0;
      sq_q   <= 1'b0;
    end else if (stop) begin
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (start) begin
      cnt_q <= pre_q;
      ps_q  <= '0;
      sq_q  <= 1'b0;
      rdy_q <= 1'b0;
      run_q <= !timer_md;
    end else begin
      if (div_sel && src) ps_q <= ps_q + 1'b1;
      if (adv) begin
        if (timer_md) begin
          if (at_end) begin
            cnt_q <= pre_q;
            sq_q  <= !sq_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else if (run_q) begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          if (at_end) begin
            rdy_q <= 1'b1;
            run_q <= 1'b0;
          end
        end
      end
    end
  end

  assign count  = cnt_q;
  assign ready  = rdy_q;
  assign sq_out = sq_q;
endmodule

// File: rtl/ctr_timer_chk.sv
module ctr_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic          start,
  input logic          stop,
  input logic [2:0]    mode_q,
  input logic [CW-1:0] count,
  input logic          ready,
  input logic          sq_out
);
  AST_RSV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'b010 && !wr_en && !start) |=> $stable(count)); // R4

  AST_RDY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (count == '0)); // R6

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ready); // R7

  AST_SQ_LOW_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[2] |-> !sq_out); // R8

  AST_SQ_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[2] && !wr_en && !start && count > CW'(1)) |=> $stable(sq_out)); // R8

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[2] && ready && !(wr_en && wr_sel == 2'd0) && !start && !stop)
      |=> (ready && $stable(count))); // R10
endmodule

bind ctr_timer ctr_timer_chk #(.CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .start(start),
  .stop(stop), .mode_q(mode_q), .count(count), .ready(ready), .sq_out(sq_out)
);

// File: tb/ctr_timer_test.sv
module ctr_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        start = 1'b0, stop = 1'b0;
  logic        ext_tick = 1'b0, txc_tick = 1'b0, xtal_tick = 1'b0;
  logic [15:0] count;
  logic        ready, sq_out;

  int checks = 0, fails = 0;

  logic [2:0]  m_mode;
  logic [15:0] m_pre, m_cnt;
  logic [3:0]  m_ps;
  logic        m_run, m_rdy, m_sq;

  always #2 clk = ~clk;

  ctr_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .stop(stop), .ext_tick(ext_tick), .txc_tick(txc_tick),
    .xtal_tick(xtal_tick), .count(count), .ready(ready), .sq_out(sq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic pick_src(input logic [2:0] md, input logic e, input logic t, input logic x);
    case (md)
      3'b000, 3'b100, 3'b101: return e;
      3'b001: return t;
      3'b011, 3'b110, 3'b111: return x;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 3'b000; m_pre = '0; m_cnt = '0; m_ps = '0;
    m_run = 1'b0; m_rdy = 1'b0; m_sq = 1'b0;
  endtask

  task automatic model_step(input logic w, input logic [1:0] s, input logic [7:0] d,
                            input logic st, input logic sp, input logic e, input logic t, input logic x);
    logic src, dv, adv;
    logic [15:0] old_pre;
    src = pick_src(m_mode, e, t, x);
    dv  = (m_mode == 3'b011) || (m_mode == 3'b101) || (m_mode == 3'b111);
    adv = dv ? (src && m_ps == 4'hF) : src;
    old_pre = m_pre;
    if (w && s == 2'd1) m_pre[7:0]  = d;
    if (w && s == 2'd2) m_pre[15:8] = d;
    if (w && s == 2'd0) begin
      m_mode = d[2:0]; m_cnt = old_pre; m_ps = '0; m_run = 0; m_rdy = 0; m_sq = 0;
    end else if (sp) begin
      m_run = 0; m_rdy = 0;
    end else if (st) begin
      m_cnt = old_pre; m_ps = '0; m_sq = 0; m_rdy = 0; m_run = !m_mode[2];
    end else begin
      if (dv && src) m_ps = m_ps + 4'd1;
      if (adv) begin
        if (m_mode[2]) begin
          if (m_cnt <= 16'd1) begin m_cnt = old_pre; m_sq = !m_sq; end
          else m_cnt = m_cnt - 16'd1;
        end else if (m_run) begin
          if (m_cnt <= 16'd1) begin m_rdy = 1; m_run = 0; end
          if (m_cnt != 0) m_cnt = m_cnt - 16'd1;
        end
      end
    end
  endtask

  task automatic cyc(input logic w, input logic [1:0] s, input logic [7:0] d,
                     input logic st, input logic sp, input logic e, input logic t, input logic x);
    wr_en = w; wr_sel = s; wr_data = d; start = st; stop = sp;
    ext_tick = e; txc_tick = t; xtal_tick = x;
    @(posedge clk);
    model_step(w, s, d, st, sp, e, t, x);
    @(negedge clk);
    wr_en = 0; start = 0; stop = 0; ext_tick = 0; txc_tick = 0; xtal_tick = 0;
    chk("R3 model count", count, m_cnt);
    chk("R3 model ready", ready, m_rdy);
    chk("R3 model sq_out", sq_out, m_sq);
  endtask

  task automatic wreg(input logic [1:0] s, input logic [7:0] d);
    cyc(1, s, d, 0, 0, 0, 0, 0);
  endtask

  task automatic idle_tick(input logic e, input logic t, input logic x);
    cyc(0, 2'd0, 8'h00, 0, 0, e, t, x);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset sq_out", sq_out, 0);
    rst_n = 1'b1;

    // R2: preload bytes, ignored select 3, reload on code write
    wreg(2'd1, 8'h34); wreg(2'd2, 8'h12); wreg(2'd3, 8'hFF);
    wreg(2'd0, 8'h01);
    chk("R2 reload from preload", count, 16'h1234);

    // R6: counter on txc_tick, preload 5
    wreg(2'd1, 8'h05); wreg(2'd2, 8'h00); wreg(2'd0, 8'h01);
    cyc(0, 2'd0, 8'h00, 1, 0, 0, 0, 0);
    chk("R6 start loads", count, 5);
    for (int i = 0; i < 4; i++) idle_tick(1, 0, 1);
    chk("R3 other sources ignored", count, 5);
    for (int i = 0; i < 4; i++) idle_tick(0, 1, 0);
    chk("R6 count before end", count, 1);
    chk("R6 ready not yet", ready, 0);
    idle_tick(0, 1, 0);
    chk("R6 ready at zero", ready, 1);
    chk("R6 count zero", count, 0);
    for (int i = 0; i < 5; i++) idle_tick(1, 1, 1);
    chk("R10 halted count", count, 0);
    chk("R10 halted ready", ready, 1);

    // R7: stop and start together
    cyc(0, 2'd0, 8'h00, 1, 1, 0, 0, 0);
    chk("R7 stop clears ready", ready, 0);
    chk("R7 stop beats start", count, 0);

    // R4: reserved code
    wreg(2'd0, 8'h02);
    cyc(0, 2'd0, 8'h00, 0, 0, 1, 1, 1);
    for (int i = 0; i < 20; i++) idle_tick(1, 1, 1);
    chk("R4 reserved frozen", count, 5);

    // R5: xtal/16 counter
    wreg(2'd0, 8'h03);
    cyc(0, 2'd0, 8'h00, 1, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) idle_tick(0, 0, 1);
    chk("R5 no step before 16", count, 5);
    idle_tick(0, 0, 1);
    chk("R5 step on 16th", count, 4);

    // R6: preload zero
    wreg(2'd1, 8'h00);
    wreg(2'd0, 8'h00);
    cyc(0, 2'd0, 8'h00, 1, 0, 0, 0, 0);
    idle_tick(1, 0, 0);
    chk("R6 zero preload ready", ready, 1);

    // R8: timer on xtal direct, preload 3
    wreg(2'd1, 8'h03);
    wreg(2'd0, 8'h06);
    idle_tick(0, 0, 1); idle_tick(0, 0, 1);
    chk("R8 sq low mid period", sq_out, 0);
    idle_tick(0, 0, 1);
    chk("R8 sq toggles", sq_out, 1);
    chk("R8 reload", count, 3);
    for (int i = 0; i < 3; i++) idle_tick(0, 0, 1);
    chk("R8 sq second edge", sq_out, 0);
    idle_tick(0, 0, 1); idle_tick(0, 0, 1); idle_tick(0, 0, 1);
    chk("R8 sq high again", sq_out, 1);
    idle_tick(0, 0, 1);
    cyc(0, 2'd0, 8'h00, 1, 0, 0, 0, 0);
    chk("R9 start reloads", count, 3);
    chk("R9 start clears sq", sq_out, 0);

    // random phase
    for (int n = 0; n < 20000; n++) begin
      logic w, st, sp;
      logic [1:0] s;
      logic [7:0] d;
      w  = ($urandom % 40) == 0;
      s  = 2'($urandom % 4);
      d  = (s == 2'd2) ? 8'(($urandom % 8) == 0) : 8'($urandom % 12);
      st = ($urandom % 30) == 0;
      sp = ($urandom % 70) == 0;
      cyc(w, s, d, st, sp, 1'($urandom), 1'($urandom), 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule